// File: doc/BRIEF.md
# Synchronous Slave-FIFO Bus Master

This block is the master side of a 16-bit synchronous slave-FIFO bus to a USB bridge device. It moves fixed blocks of 256 sixteen-bit words (512 bytes) in both directions. Read blocks come from bridge thread 0 and go to a local sink. Write blocks come from a local show-ahead source and go to bridge thread 3. The block drives chip-select, read strobe, write strobe, output enable, packet-end and the 2-bit thread address. It watches one dedicated ready flag for each thread. No partial or watermark flags are used: the block decides a burst only from the two flags and its own word count.

The bridge returns read data a fixed number of cycles after it samples the read strobe. The block holds each strobe for exactly one block length. It then keeps output enable asserted and captures data for the latency cycles after the read strobe drops. Only after that does it look at the flags again. As a result it never asks for a word past an empty read buffer, and it never pushes a word past a full write buffer. When both directions are ready, the block alternates between them. A saturating counter records every strobe cycle issued while the matching flag showed not-ready.

Top module: `sfifo_bus_master`

## Requirements
- R1: While rst_n is low and in the cycle after, chip-select, read strobe, write strobe, output enable and packet-end are all high (inactive). The data drive enable, src_pop_o and snk_valid_o are low, and err_cnt_o is 0.
- R2: A read burst starts only when sf_flag_rd is high. Its read strobe (sf_rd_n low) lasts exactly 256 consecutive cycles.
- R3: sf_addr is 0 during every read strobe cycle and 3 during every write strobe cycle. It changes only in cycles where both strobes are high, both in that cycle and in the one before.
- R4: sf_oe_n goes low in the cycle before the first read strobe of a burst. It stays low through the strobe and for 2 cycles after it. sf_dq_drive is never high while sf_oe_n is low.
- R5: The bridge presents a word on sf_dq_i 2 cycles after the strobe cycle that requested it. Each such word appears on snk_data_o with snk_valid_o high one cycle later, in bus order. Exactly 256 words are requested per block, so a drained read buffer is never strobed.
- R6: A write burst holds sf_wr_n low for exactly 256 cycles. In each of those cycles sf_dq_drive and src_pop_o are high and sf_dq_o equals src_data_i of the same cycle. A full write buffer is never strobed.
- R7: A write burst starts only when sf_flag_wr and src_avail_i are both high. With bridge space but no full source block, no write strobe is issued.
- R8: Every new strobe run is preceded by a cycle in which both strobes are high and sf_addr already holds the new thread value.
- R9: When both directions are ready at the same decision point, the direction not served last is chosen. Sustained demand on both sides therefore gives read, write, read, write. The first decision after reset favours read.
- R10: err_cnt_o increases by one for each cycle in which the read strobe is low while sf_flag_rd is low, or the write strobe is low while sf_flag_wr is low. It saturates at its maximum and is otherwise unchanged.
- R11: sf_cs_n is low whenever either strobe is low. sf_pktend_n stays high, because every block is full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sf_cs_n | output | 1 | Chip-select, low while a burst is in progress |
| sf_rd_n | output | 1 | Read strobe, low active |
| sf_wr_n | output | 1 | Write strobe, low active |
| sf_oe_n | output | 1 | Output enable to the bridge, low active |
| sf_pktend_n | output | 1 | Short-packet end, held inactive |
| sf_addr | output | 2 | Thread address (0 read, 3 write) |
| sf_dq_i | input | 16 | Data bus as driven by the bridge |
| sf_dq_o | output | 16 | Data bus as driven by the master |
| sf_dq_drive | output | 1 | Master drives the data bus when high |
| sf_flag_rd | input | 1 | Read thread flag, high while data is buffered |
| sf_flag_wr | input | 1 | Write thread flag, high while space is free |
| src_data_i | input | 16 | Head word of the local source |
| src_avail_i | input | 1 | Local source holds at least one full block |
| src_pop_o | output | 1 | Consume the source head word |
| snk_data_o | output | 16 | Word captured from a read burst |
| snk_valid_o | output | 1 | snk_data_o holds a new word |
| err_cnt_o | output | 8 | Count of strobe cycles issued against a not-ready flag |

## Verification
The assertions assume that the bridge flags change only in whole blocks, and that a flag stays high from the decision point to the end of the burst it allowed. The write-length check also assumes that the source keeps a full block once src_avail_i is raised. The bench bridge model follows these rules. It raises a flag only after loading or freeing 256 words, and it lowers the flag only when its buffer level reaches zero. The one exception is a deliberate three-cycle flag drop inside a read burst, which exercises the error counter.

// File: rtl/sfm_pkg.sv
// Shared types for the slave-FIFO bus master.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sfm_pkg;

    // Burst phases of the bus sequencer
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RD_SETUP  = 3'd1,
        ST_RD_STROBE = 3'd2,
        ST_RD_DRAIN  = 3'd3,
        ST_WR_SETUP  = 3'd4,
        ST_WR_STROBE = 3'd5
    } sfm_state_e;

    // Direction last granted, used for alternating arbitration
    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } sfm_dir_e;

endpackage

// File: rtl/sfm_sequencer.sv
// Burst sequencer: chooses a direction, sets the thread address during a setup
// cycle with both strobes idle, holds one strobe for BLOCK_WORDS cycles and,
// for reads, waits RD_LAT drain cycles before deciding again.
// Assumes flags change only in whole blocks and RD_LAT >= 1.
module sfm_sequencer
    import sfm_pkg::*;
#(
    parameter int BLOCK_WORDS = 256,
    parameter int RD_LAT      = 2,
    parameter int ADDR_W      = 2,
    parameter int RD_THREAD   = 0,
    parameter int WR_THREAD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_rd_i,
    input  logic              flag_wr_i,
    input  logic              src_avail_i,
    output logic              rd_go_o,
    output logic              wr_go_o,
    output logic              oe_act_o,
    output logic              sel_act_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int SPAN  = (BLOCK_WORDS > RD_LAT) ? BLOCK_WORDS : RD_LAT;
    localparam int CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] LAST_WORD  = CNT_W'(BLOCK_WORDS - 1);
    localparam logic [CNT_W-1:0] LAST_DRAIN = CNT_W'(RD_LAT - 1);

    sfm_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    sfm_dir_e          last_q, last_d;
    logic              rd_ok, wr_ok, pick_rd, pick_wr;

    // Arbitration: ready sides, ties broken toward the side not served last
    always_comb begin
        rd_ok   = flag_rd_i;
        wr_ok   = flag_wr_i && src_avail_i;
        pick_rd = rd_ok && (!wr_ok || (last_q == DIR_WR));
        pick_wr = wr_ok && !pick_rd;
    end

    // Next-state, counter and address selection
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        addr_d  = addr_q;
        last_d  = last_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (pick_rd) begin
                    state_d = ST_RD_SETUP;
                    addr_d  = ADDR_W'(RD_THREAD);
                    last_d  = DIR_RD;
                end else if (pick_wr) begin
                    state_d = ST_WR_SETUP;
                    addr_d  = ADDR_W'(WR_THREAD);
                    last_d  = DIR_WR;
                end
            end
            ST_RD_SETUP:  state_d = ST_RD_STROBE;
            ST_RD_STROBE: begin
                if (cnt_q == LAST_WORD) begin
                    state_d = ST_RD_DRAIN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RD_DRAIN: begin
                if (cnt_q == LAST_DRAIN) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WR_SETUP:  state_d = ST_WR_STROBE;
            ST_WR_STROBE: begin
                if (cnt_q == LAST_WORD) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= ADDR_W'(RD_THREAD);
            last_q  <= DIR_WR;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
            last_q  <= last_d;
        end
    end

    // Bus phase decode
    always_comb begin
        rd_go_o   = (state_q == ST_RD_STROBE);
        wr_go_o   = (state_q == ST_WR_STROBE);
        oe_act_o  = (state_q == ST_RD_SETUP) || (state_q == ST_RD_STROBE)
                 || (state_q == ST_RD_DRAIN);
        sel_act_o = (state_q != ST_IDLE);
        addr_o    = addr_q;
    end

    // R3: thread address is frozen while any strobe runs
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go_o || wr_go_o) |-> $stable(addr_q));

    // R4: output enable leads the read strobe by at least a cycle
    p_oe_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_go_o) |-> $past(oe_act_o));

    // R8: a new read strobe never follows a write strobe directly
    p_gap_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_go_o) |-> $past(!wr_go_o));

    // R8: a new write strobe never follows a read strobe directly
    p_gap_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_go_o) |-> $past(!rd_go_o));

    // R3: read strobes target the read thread, write strobes the write thread
    p_thread_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go_o |-> addr_o == ADDR_W'(RD_THREAD)) and
        (wr_go_o |-> addr_o == ADDR_W'(WR_THREAD)));

endmodule

// File: rtl/sfm_rd_capture.sv
// Read-data capture: delays each read request by the bridge latency and
// registers the bus word into the sink when its request reaches the end.
// Assumes the bridge presents data exactly RD_LAT cycles after the strobe.
module sfm_rd_capture #(
    parameter int DW     = 16,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [DW-1:0] dq_i,
    output logic [DW-1:0] snk_data_o,
    output logic          snk_valid_o
);
    localparam int OUT_W = $clog2(RD_LAT + 2) + 1;

    logic [RD_LAT-1:0] vpipe_q;
    logic              take;

    // Latency pipeline of outstanding requests
    generate
        if (RD_LAT == 1) begin : g_lat_one
            always_ff @(posedge clk) begin
                if (!rst_n) vpipe_q <= '0;
                else        vpipe_q <= req_i;
            end
        end else begin : g_lat_multi
            always_ff @(posedge clk) begin
                if (!rst_n) vpipe_q <= '0;
                else        vpipe_q <= {vpipe_q[RD_LAT-2:0], req_i};
            end
        end
    endgenerate

    assign take = vpipe_q[RD_LAT-1];

    // Sink register: captures the bus word whose request has matured
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snk_valid_o <= 1'b0;
            snk_data_o  <= '0;
        end else begin
            snk_valid_o <= take;
            if (take) snk_data_o <= dq_i;
        end
    end

    // Outstanding-request tally used only by the check below
    logic [OUT_W-1:0] a_outst_q;
    always_ff @(posedge clk) begin
        if (!rst_n) a_outst_q <= '0;
        else        a_outst_q <= a_outst_q + OUT_W'(req_i) - OUT_W'(snk_valid_o);
    end

    // R5: no word reaches the sink without a matching earlier request
    p_no_extra_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snk_valid_o |-> a_outst_q != '0);

endmodule

// File: rtl/sfm_fault_counter.sv
// Fault counter: counts strobe cycles issued while the flag of the addressed
// thread reports not-ready; saturates at its maximum value.
// Assumes the two strobe inputs are never active together.
module sfm_fault_counter #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go_i,
    input  logic             wr_go_i,
    input  logic             flag_rd_i,
    input  logic             flag_wr_i,
    output logic [ERR_W-1:0] err_cnt_o
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic fault;

    // Strobe against a not-ready thread
    assign fault = (rd_go_i && !flag_rd_i) || (wr_go_i && !flag_wr_i);

    // Saturating counter register
    always_ff @(posedge clk) begin
        if (!rst_n)                            err_cnt_o <= '0;
        else if (fault && err_cnt_o != ERR_MAX) err_cnt_o <= err_cnt_o + 1'b1;
    end

    // R10: counter holds when no faulty strobe is seen
    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !((rd_go_i && !flag_rd_i) || (wr_go_i && !flag_wr_i)) |=> $stable(err_cnt_o));

    // R10: counter never moves by more than one per cycle
    p_err_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (err_cnt_o == $past(err_cnt_o) || err_cnt_o == $past(err_cnt_o) + 1'b1));

endmodule

// File: rtl/sfifo_bus_master.sv
// Synchronous slave-FIFO bus master: block-sized read and write bursts over
// a 16-bit bus, latency-aware capture, alternating arbitration and a fault
// counter. Assumes a show-ahead local source and an always-ready sink.
module sfifo_bus_master
    import sfm_pkg::*;
#(
    parameter int DW          = 16,
    parameter int ADDR_W      = 2,
    parameter int BLOCK_WORDS = 256,
    parameter int RD_LAT      = 2,
    parameter int RD_THREAD   = 0,
    parameter int WR_THREAD   = 3,
    parameter int ERR_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sf_cs_n,
    output logic              sf_rd_n,
    output logic              sf_wr_n,
    output logic              sf_oe_n,
    output logic              sf_pktend_n,
    output logic [ADDR_W-1:0] sf_addr,
    input  logic [DW-1:0]     sf_dq_i,
    output logic [DW-1:0]     sf_dq_o,
    output logic              sf_dq_drive,
    input  logic              sf_flag_rd,
    input  logic              sf_flag_wr,
    input  logic [DW-1:0]     src_data_i,
    input  logic              src_avail_i,
    output logic              src_pop_o,
    output logic [DW-1:0]     snk_data_o,
    output logic              snk_valid_o,
    output logic [ERR_W-1:0]  err_cnt_o
);
    localparam int RUN_W = $clog2(BLOCK_WORDS + 1) + 1;

    logic rd_go, wr_go, oe_act, sel_act;

    sfm_sequencer #(
        .BLOCK_WORDS (BLOCK_WORDS),
        .RD_LAT      (RD_LAT),
        .ADDR_W      (ADDR_W),
        .RD_THREAD   (RD_THREAD),
        .WR_THREAD   (WR_THREAD)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_rd_i   (sf_flag_rd),
        .flag_wr_i   (sf_flag_wr),
        .src_avail_i (src_avail_i),
        .rd_go_o     (rd_go),
        .wr_go_o     (wr_go),
        .oe_act_o    (oe_act),
        .sel_act_o   (sel_act),
        .addr_o      (sf_addr)
    );

    sfm_rd_capture #(
        .DW     (DW),
        .RD_LAT (RD_LAT)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (rd_go),
        .dq_i        (sf_dq_i),
        .snk_data_o  (snk_data_o),
        .snk_valid_o (snk_valid_o)
    );

    sfm_fault_counter #(
        .ERR_W (ERR_W)
    ) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_go_i   (rd_go),
        .wr_go_i   (wr_go),
        .flag_rd_i (sf_flag_rd),
        .flag_wr_i (sf_flag_wr),
        .err_cnt_o (err_cnt_o)
    );

    // Bus pin mapping: low-active controls, write data passes from the source
    always_comb begin
        sf_cs_n     = !sel_act;
        sf_rd_n     = !rd_go;
        sf_wr_n     = !wr_go;
        sf_oe_n     = !oe_act;
        sf_pktend_n = 1'b1;
        sf_dq_drive = wr_go;
        sf_dq_o     = wr_go ? src_data_i : '0;
        src_pop_o   = wr_go;
    end

    // Strobe run length tally used only by the checks below
    logic [RUN_W-1:0] a_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  a_run_q <= '0;
        else if (!sf_rd_n || !sf_wr_n) a_run_q <= a_run_q + 1'b1;
        else                         a_run_q <= '0;
    end

    // R2: every read strobe run is exactly one block long
    p_rd_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sf_rd_n) |-> a_run_q == RUN_W'(BLOCK_WORDS));

    // R6: every write strobe run is exactly one block long
    p_wr_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sf_wr_n) |-> a_run_q == RUN_W'(BLOCK_WORDS));

    // R4: the master leaves the bus undriven while the bridge may drive it
    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_oe_n |-> !sf_dq_drive);

    // R11: strobes only occur with chip-select asserted
    p_cs_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sf_rd_n || !sf_wr_n) |-> !sf_cs_n);

    // R6: one source word is consumed per write strobe cycle
    p_pop_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop_o |-> (!sf_wr_n && sf_dq_drive));

endmodule

// File: tb/tb_sfifo_bus_master.sv
`timescale 1ns/1ps
module tb_sfifo_bus_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sf_cs_n, sf_rd_n, sf_wr_n, sf_oe_n, sf_pktend_n, sf_dq_drive;
    logic [1:0]  sf_addr;
    logic [15:0] sf_dq_i, sf_dq_o, src_data, snk_data;
    logic        sf_flag_rd, sf_flag_wr, src_avail, src_pop, snk_valid;
    logic [7:0]  err_cnt;

    always #2.5 clk = ~clk;

    sfifo_bus_master dut (
        .clk(clk), .rst_n(rst_n), .sf_cs_n(sf_cs_n), .sf_rd_n(sf_rd_n),
        .sf_wr_n(sf_wr_n), .sf_oe_n(sf_oe_n), .sf_pktend_n(sf_pktend_n),
        .sf_addr(sf_addr), .sf_dq_i(sf_dq_i), .sf_dq_o(sf_dq_o),
        .sf_dq_drive(sf_dq_drive), .sf_flag_rd(sf_flag_rd), .sf_flag_wr(sf_flag_wr),
        .src_data_i(src_data), .src_avail_i(src_avail), .src_pop_o(src_pop),
        .snk_data_o(snk_data), .snk_valid_o(snk_valid), .err_cnt_o(err_cnt)
    );

    int total = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bridge model and local source, block-granular buffers
    logic [15:0] rd_mem [1024];
    logic [15:0] src_mem [1024];
    int rd_wp = 0, rd_rp = 0, src_wp = 0, src_rp = 0, wr_space = 0;
    int underruns = 0, overruns = 0;
    bit kill_rd = 1'b0;
    logic [15:0] p1 = '0, dq_r = '0;
    logic [15:0] exp_rd[$];
    logic [15:0] exp_wr[$];

    assign sf_flag_rd = ((rd_wp - rd_rp) != 0) && !kill_rd;
    assign sf_flag_wr = (wr_space != 0);
    assign sf_dq_i    = dq_r;
    assign src_data   = src_mem[src_rp % 1024];
    assign src_avail  = (src_wp - src_rp) >= 256;

    always @(posedge clk) begin
        if (rst_n) begin
            dq_r <= p1;
            if (!sf_cs_n && !sf_rd_n && sf_addr == 2'd0) begin
                if (rd_wp == rd_rp) underruns++;
                else begin
                    p1 <= rd_mem[rd_rp % 1024];
                    rd_rp <= rd_rp + 1;
                end
            end
            if (!sf_cs_n && !sf_wr_n && sf_addr == 2'd3) begin
                if (wr_space == 0) overruns++;
                else begin
                    wr_space <= wr_space - 1;
                    if (exp_wr.size() == 0) check(0, "R6", "unexpected write word", sf_dq_o, 0);
                    else begin
                        logic [15:0] e;
                        e = exp_wr.pop_front();
                        check(sf_dq_drive && sf_dq_o == e, "R6", "write word", sf_dq_o, e);
                    end
                end
            end
            if (src_pop) src_rp <= src_rp + 1;
        end
    end

    // Drivers: push blocks into the bridge/source and the scoreboard
    task automatic load_rd_block(input int seed);
        for (int i = 0; i < 256; i++) begin
            logic [15:0] w;
            w = 16'(seed * 16'h1357) ^ 16'(i * 37) ^ 16'(i << 8);
            rd_mem[rd_wp % 1024] = w;
            exp_rd.push_back(w);
            rd_wp = rd_wp + 1;
        end
    endtask

    task automatic load_src_block(input int seed);
        for (int i = 0; i < 256; i++) begin
            logic [15:0] w;
            w = ((i % 2) == 0 ? 16'hAAAA : 16'h5555) ^ 16'(seed * 16'h0F1) ^ 16'(i);
            src_mem[src_wp % 1024] = w;
            exp_wr.push_back(w);
            src_wp = src_wp + 1;
        end
    endtask

    // Monitor: sink scoreboard and bus protocol observations
    bit prev_rd_n = 1, prev_wr_n = 1, prev_oe_n = 1;
    logic [1:0] prev_addr = '0;
    int run = 0;
    int v_addr = 0, v_drive = 0, v_pkt = 0, v_cs = 0;
    bit dir_log[$];

    always @(negedge clk) begin
        if (rst_n) begin
            if (snk_valid) begin
                if (exp_rd.size() == 0) check(0, "R5", "unexpected sink word", snk_data, 0);
                else begin
                    logic [15:0] e;
                    e = exp_rd.pop_front();
                    check(snk_data == e, "R5", "sink word", snk_data, e);
                end
            end
            if (!sf_rd_n && prev_rd_n) begin
                check(!prev_oe_n, "R4", "oe before read strobe", prev_oe_n, 0);
                check(sf_addr == 2'd0, "R3", "read thread", sf_addr, 0);
                check(sf_flag_rd, "R2", "read start flag", sf_flag_rd, 1);
                check(prev_wr_n && prev_addr == sf_addr, "R8", "idle cycle before read", prev_addr, sf_addr);
                dir_log.push_back(1'b0);
            end
            if (!sf_wr_n && prev_wr_n) begin
                check(sf_addr == 2'd3, "R3", "write thread", sf_addr, 3);
                check(sf_flag_wr && src_avail, "R7", "write start ready", {sf_flag_wr, src_avail}, 3);
                check(prev_rd_n && prev_addr == sf_addr, "R8", "idle cycle before write", prev_addr, sf_addr);
                dir_log.push_back(1'b1);
            end
            if (sf_rd_n && !prev_rd_n) begin
                check(run == 256, "R2", "read strobe length", run, 256);
                check(!sf_oe_n, "R4", "oe held after strobe", sf_oe_n, 0);
            end
            if (sf_wr_n && !prev_wr_n) check(run == 256, "R6", "write strobe length", run, 256);
            if (!sf_rd_n || !sf_wr_n) run++;
            else run = 0;
            if (sf_addr != prev_addr && (!sf_rd_n || !sf_wr_n || !prev_rd_n || !prev_wr_n)) v_addr++;
            if (sf_dq_drive && !sf_oe_n) v_drive++;
            if (!sf_pktend_n) v_pkt++;
            if ((!sf_rd_n || !sf_wr_n) && sf_cs_n) v_cs++;
            prev_rd_n = sf_rd_n;
            prev_wr_n = sf_wr_n;
            prev_oe_n = sf_oe_n;
            prev_addr = sf_addr;
        end
    end

    task automatic wait_quiet(input string req);
        int quiet = 0;
        int guard = 0;
        while (quiet < 4 && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (exp_rd.size() == 0 && exp_wr.size() == 0 && sf_cs_n) quiet++;
            else quiet = 0;
        end
        check(quiet >= 4, req, "bursts completed", guard, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        int strobes;
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sf_cs_n && sf_rd_n && sf_wr_n && sf_oe_n && sf_pktend_n, "R1", "controls idle",
              {sf_cs_n, sf_rd_n, sf_wr_n, sf_oe_n, sf_pktend_n}, 5'h1f);
        check(!sf_dq_drive && !src_pop && !snk_valid, "R1", "drive/pop/valid low",
              {sf_dq_drive, src_pop, snk_valid}, 0);
        check(err_cnt == 0, "R1", "error count", err_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sf_cs_n && sf_rd_n && sf_wr_n, "R1", "idle after reset", {sf_cs_n, sf_rd_n, sf_wr_n}, 7);

        // R2/R7: no flags, no bursts
        strobes = 0;
        repeat (20) begin
            @(negedge clk);
            if (!sf_rd_n || !sf_wr_n) strobes++;
        end
        check(strobes == 0, "R2", "no strobe without flags", strobes, 0);

        // R2/R5: one read block
        load_rd_block(1);
        wait_quiet("R5");

        // R6: one write block
        wr_space = wr_space + 256;
        load_src_block(2);
        wait_quiet("R6");

        // R9: both sides ready for two blocks each
        base = dir_log.size();
        load_rd_block(3);
        load_rd_block(4);
        wr_space = wr_space + 512;
        load_src_block(5);
        load_src_block(6);
        wait_quiet("R9");
        check(dir_log.size() == base + 4, "R9", "burst count", dir_log.size() - base, 4);
        if (dir_log.size() == base + 4)
            check(!dir_log[base] && dir_log[base+1] && !dir_log[base+2] && dir_log[base+3],
                  "R9", "alternation order",
                  {dir_log[base], dir_log[base+1], dir_log[base+2], dir_log[base+3]}, 4'b0101);

        // R7: bridge space but no source block
        wr_space = wr_space + 256;
        strobes = 0;
        repeat (40) begin
            @(negedge clk);
            if (!sf_wr_n) strobes++;
        end
        check(strobes == 0, "R7", "no write without source", strobes, 0);
        load_src_block(7);
        wait_quiet("R7");
        check(err_cnt == 0, "R10", "no faults in clean traffic", err_cnt, 0);

        // R10: read flag dropped for three cycles during a burst
        load_rd_block(8);
        begin
            int guard = 0;
            while (sf_rd_n && guard < 100) begin
                @(negedge clk);
                guard++;
            end
        end
        repeat (10) @(negedge clk);
        kill_rd = 1'b1;
        repeat (3) @(negedge clk);
        kill_rd = 1'b0;
        wait_quiet("R10");
        check(err_cnt == 3, "R10", "fault count", err_cnt, 3);

        // End-of-run protocol tallies
        check(underruns == 0, "R5", "bridge underruns", underruns, 0);
        check(overruns == 0, "R6", "bridge overruns", overruns, 0);
        check(v_addr == 0, "R3", "address moved near strobe", v_addr, 0);
        check(v_drive == 0, "R4", "drive during oe", v_drive, 0);
        check(v_cs == 0, "R11", "strobe without chip-select", v_cs, 0);
        check(v_pkt == 0, "R11", "packet-end asserted", v_pkt, 0);
        summary();
        $finish;
    end
endmodule